// File: doc/BRIEF.md
# Triggered Chirp Waveform Playback Engine

This block replays a stored chirp, one sample per clock, each time a trigger rises. A bank of sixteen independent sample sets is held in on-chip memory. A 4-bit select input picks the set for the next chirp. Because the sets are independent, one base chirp can be stored several times with different Doppler pre-corrections, or as up-chirp and down-chirp variants. Playback treats every set the same way, whatever its shape or modulation law.

The select value and the programmable pre-delay are both captured when a trigger is accepted. Changing either input during a chirp therefore has no effect until the next trigger. The pre-delay keeps the trigger-to-chirp timing in line with older analog chirp generators. Each set has its own last-index register that fixes the chirp length. Between chirps the DAC data word sits at zero, which is mid-scale for two's complement data. The bank is loaded through a plain write port. Writes that target the set being played are dropped.

Top module: `chirp_player`

## Requirements
- R1: After reset, `dac_data`, `busy` and `overrun` are all zero, and every last-index register holds 0.
- R2: Let edge E1 be the first clock edge that samples `trig_in` high after a low sample. The trigger is accepted at edge E(SYNC_STAGES+1), which is E3 with the default settings. Sample k of the set appears on `dac_data` after edge E(SYNC_STAGES+D+2+k).
- R3: A chirp presents stored indices 0 through L in order, where L is the set's last-index register. After that, `dac_data` returns to 0.
- R4: `wave_sel` is captured at the acceptance edge. A change to it during the pre-delay or during playback does not alter the chirp in progress.
- R5: `delay_cycles` gives D, the extra clocks between acceptance and the first sample. It is captured at acceptance, and D = 0 is allowed.
- R6: `busy` is high from the edge after acceptance until the edge after the last sample has been presented, and low otherwise.
- R7: A trigger rising edge that arrives while `busy` is high is ignored. It sets `overrun`, which stays high until reset.
- R8: A trigger held high for many cycles starts exactly one chirp.
- R9: While `busy` is high, sample writes and last-index writes to the set being played are ignored. Writes to other sets take effect.
- R10: `wr_addr` is {set, index}: the set number sits in the upper SEL_W bits and the sample index in the lower IDX_W bits.
- R11: `dac_data` is 0 on every clock in which no chirp sample is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Trigger; a chirp starts on its rising edge |
| wave_sel | input | SEL_W (4) | Set to use for the next accepted trigger |
| delay_cycles | input | DELAY_W (12) | Extra pre-delay in clocks |
| wr_en | input | 1 | Sample write strobe |
| wr_addr | input | SEL_W+IDX_W (10) | Sample address {set, index} |
| wr_data | input | SAMPLE_W (16) | Sample value |
| len_wr_en | input | 1 | Last-index write strobe |
| len_wr_set | input | SEL_W (4) | Set whose last index is written |
| len_wr_last | input | IDX_W (6) | Index of the final sample of that set |
| dac_data | output | SAMPLE_W (16) | Sample word to the DAC |
| busy | output | 1 | Chirp or pre-delay in progress |
| overrun | output | 1 | Sticky flag for an ignored trigger |

## Verification
The first sample of a chirp is due SYNC_STAGES+D+2 edges after the first edge that sees the trigger high. Sample k follows k edges later. `busy` rises one edge after acceptance and falls one edge after the last sample. `overrun` rises one edge after a trigger edge that arrives while busy. The bench model counts edges from reset and places every expected value on the edge it belongs to. It applies this timing to the sample data, `busy` and `overrun`, then compares all three in the middle of every clock cycle. Stimulus is driven on falling edges, so no comparison depends on the order in which processes run at the rising edge.

// File: rtl/cp_pkg.sv
package cp_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_WAIT = 2'd1,
      SEQ_PLAY = 2'd2
   } seq_state_t;
endpackage

// File: rtl/cp_trig_edge.sv
module cp_trig_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_in,
   output logic trig_edge
);
   logic trig_s;
   logic trig_prev;

   generate
      if (SYNC_STAGES < 0) begin : g_bad
         $error("cp_trig_edge: SYNC_STAGES must not be negative");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign trig_s = trig_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain <= '0;
            end else begin
               chain[0] <= trig_in;
               for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
            end
         end
         assign trig_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trig_prev <= 1'b0;
      else        trig_prev <= trig_s;
   end

   assign trig_edge = trig_s & ~trig_prev;

   // An edge pulse never lasts two cycles (R8)
   assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_edge |=> !trig_edge);
endmodule

// File: rtl/cp_wave_bank.sv
module cp_wave_bank #(
   parameter int SAMPLE_W  = 16,
   parameter int SET_COUNT = 16,
   parameter int SET_DEPTH = 64,
   localparam int SEL_W    = $clog2(SET_COUNT),
   localparam int IDX_W    = $clog2(SET_DEPTH),
   localparam int ADDR_W   = SEL_W + IDX_W,
   localparam int WORDS    = SET_COUNT * SET_DEPTH
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [SAMPLE_W-1:0] wr_data,
   input  logic                len_wr_en,
   input  logic [SEL_W-1:0]    len_wr_set,
   input  logic [IDX_W-1:0]    len_wr_last,
   input  logic                busy,
   input  logic [SEL_W-1:0]    act_set,
   input  logic [SEL_W-1:0]    sel_in,
   output logic [IDX_W-1:0]    sel_last,
   input  logic                rd_en,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [SAMPLE_W-1:0] dac_data
);
   logic [SAMPLE_W-1:0] mem [WORDS];
   logic [IDX_W-1:0]    last_regs [SET_COUNT];
   logic [SEL_W-1:0]    wr_set;
   logic                wr_ok;
   logic                len_ok;
   logic [ADDR_W-1:0]   rd_addr;

   assign wr_set   = wr_addr[ADDR_W-1 -: SEL_W];
   assign wr_ok    = wr_en && !(busy && (wr_set == act_set));
   assign len_ok   = len_wr_en && !(busy && (len_wr_set == act_set));
   assign rd_addr  = {act_set, rd_idx};
   assign sel_last = last_regs[sel_in];

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SET_COUNT; s++) last_regs[s] <= '0;
      end else if (len_ok) begin
         last_regs[len_wr_set] <= len_wr_last;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     dac_data <= '0;
      else if (rd_en) dac_data <= mem[rd_addr];
      else            dac_data <= '0;
   end

   // Output idles at mid-scale zero whenever no sample was read (R11)
   assert_zero_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (dac_data == '0));
   // Protected set's last index does not move while it is played (R9)
   assert_len_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && len_wr_en && (len_wr_set == act_set))
      |=> (last_regs[$past(len_wr_set)] == $past(last_regs[len_wr_set])));
endmodule

// File: rtl/cp_sequencer.sv
module cp_sequencer #(
   parameter int SEL_W   = 4,
   parameter int IDX_W   = 6,
   parameter int DELAY_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_edge,
   input  logic [SEL_W-1:0]   sel_in,
   input  logic [DELAY_W-1:0] delay_in,
   input  logic [IDX_W-1:0]   last_in,
   output logic               busy,
   output logic               overrun,
   output logic [SEL_W-1:0]   act_set,
   output logic [IDX_W-1:0]   rd_idx,
   output logic               rd_en
);
   import cp_pkg::*;

   seq_state_t         state;
   logic [DELAY_W-1:0] wait_cnt;
   logic [IDX_W-1:0]   last_q;
   logic               play_q;
   logic               accept;

   assign busy   = (state != SEQ_IDLE) || play_q;
   assign accept = trig_edge && !busy;
   assign rd_en  = (state == SEQ_PLAY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         wait_cnt <= '0;
         last_q   <= '0;
         rd_idx   <= '0;
         act_set  <= '0;
         play_q   <= 1'b0;
         overrun  <= 1'b0;
      end else begin
         play_q <= (state == SEQ_PLAY);
         if (trig_edge && busy) overrun <= 1'b1;
         unique case (state)
            SEQ_IDLE: begin
               if (accept) begin
                  act_set  <= sel_in;
                  last_q   <= last_in;
                  rd_idx   <= '0;
                  wait_cnt <= delay_in;
                  state    <= (delay_in == '0) ? SEQ_PLAY : SEQ_WAIT;
               end
            end
            SEQ_WAIT: begin
               wait_cnt <= wait_cnt - 1'b1;
               if (wait_cnt == DELAY_W'(1)) state <= SEQ_PLAY;
            end
            SEQ_PLAY: begin
               if (rd_idx == last_q) state <= SEQ_IDLE;
               else                  rd_idx <= rd_idx + 1'b1;
            end
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   // Accepted trigger raises busy on the next edge (R6)
   assert_busy_after_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy);
   // Trigger edge during a chirp sets the sticky flag (R7)
   assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge && busy) |=> overrun);
   // Sticky flag never clears outside reset (R7)
   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   // Played set is frozen for the whole chirp (R4)
   assert_set_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state != SEQ_IDLE) |=> $stable(act_set));
   // Read index never passes the latched last index (R3)
   assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SEQ_PLAY) |-> (rd_idx <= last_q));
endmodule

// File: rtl/chirp_player.sv
module chirp_player #(
   parameter int SAMPLE_W    = 16,
   parameter int SET_COUNT   = 16,
   parameter int SET_DEPTH   = 64,
   parameter int DELAY_W     = 12,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = $clog2(SET_COUNT),
   localparam int IDX_W      = $clog2(SET_DEPTH),
   localparam int ADDR_W     = SEL_W + IDX_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                trig_in,
   input  logic [SEL_W-1:0]    wave_sel,
   input  logic [DELAY_W-1:0]  delay_cycles,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [SAMPLE_W-1:0] wr_data,
   input  logic                len_wr_en,
   input  logic [SEL_W-1:0]    len_wr_set,
   input  logic [IDX_W-1:0]    len_wr_last,
   output logic [SAMPLE_W-1:0] dac_data,
   output logic                busy,
   output logic                overrun
);
   generate
      if ((1 << SEL_W) != SET_COUNT || SET_COUNT < 2) begin : g_chk_sets
         $error("chirp_player: SET_COUNT must be a power of two of at least 2");
      end
      if ((1 << IDX_W) != SET_DEPTH || SET_DEPTH < 2) begin : g_chk_depth
         $error("chirp_player: SET_DEPTH must be a power of two of at least 2");
      end
      if (SAMPLE_W < 2 || DELAY_W < 1) begin : g_chk_width
         $error("chirp_player: SAMPLE_W or DELAY_W too small");
      end
   endgenerate

   logic             trig_edge;
   logic [SEL_W-1:0] act_set;
   logic [IDX_W-1:0] sel_last;
   logic [IDX_W-1:0] rd_idx;
   logic             rd_en;

   cp_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .trig_edge(trig_edge));

   cp_sequencer #(.SEL_W(SEL_W), .IDX_W(IDX_W), .DELAY_W(DELAY_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .trig_edge(trig_edge), .sel_in(wave_sel),
      .delay_in(delay_cycles), .last_in(sel_last), .busy(busy),
      .overrun(overrun), .act_set(act_set), .rd_idx(rd_idx), .rd_en(rd_en));

   cp_wave_bank #(.SAMPLE_W(SAMPLE_W), .SET_COUNT(SET_COUNT), .SET_DEPTH(SET_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .len_wr_en(len_wr_en), .len_wr_set(len_wr_set),
      .len_wr_last(len_wr_last), .busy(busy), .act_set(act_set),
      .sel_in(wave_sel), .sel_last(sel_last), .rd_en(rd_en),
      .rd_idx(rd_idx), .dac_data(dac_data));

   // Samples only leave while a chirp is in progress (R11)
   assert_data_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (dac_data == '0));
endmodule

// File: tb/chirp_player_tb.sv
`timescale 1ns/1ps
module chirp_player_tb_top;
   localparam int SAMPLE_W = 16;
   localparam int SETS     = 16;
   localparam int DEPTH    = 64;
   localparam int DELAY_W  = 12;
   localparam int SYNC     = 2;
   localparam int SEL_W    = 4;
   localparam int IDX_W    = 6;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                trig_in = 1'b0;
   logic [SEL_W-1:0]    wave_sel = '0;
   logic [DELAY_W-1:0]  delay_cycles = '0;
   logic                wr_en = 1'b0;
   logic [SEL_W+IDX_W-1:0] wr_addr = '0;
   logic [SAMPLE_W-1:0] wr_data = '0;
   logic                len_wr_en = 1'b0;
   logic [SEL_W-1:0]    len_wr_set = '0;
   logic [IDX_W-1:0]    len_wr_last = '0;
   logic [SAMPLE_W-1:0] dac_data;
   logic                busy;
   logic                overrun;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   chirp_player #(.SAMPLE_W(SAMPLE_W), .SET_COUNT(SETS), .SET_DEPTH(DEPTH),
                  .DELAY_W(DELAY_W), .SYNC_STAGES(SYNC)) dut_i (
      .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .wave_sel(wave_sel),
      .delay_cycles(delay_cycles), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .len_wr_en(len_wr_en), .len_wr_set(len_wr_set),
      .len_wr_last(len_wr_last), .dac_data(dac_data), .busy(busy),
      .overrun(overrun));

   // ---------------- reference model ----------------
   logic [SAMPLE_W-1:0] m_mem [SETS*DEPTH];
   int   m_last [SETS];
   bit   m_hist [$];
   bit   m_prev;
   int   n, acc_c, start_c, end_c, m_set, m_len;
   bit   m_ov;
   logic [SAMPLE_W-1:0] exp_dac;
   bit   exp_busy;
   bit   model_live = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         n = 0; acc_c = 1; start_c = 1; end_c = 0; m_set = 0; m_len = 0;
         m_ov = 0; m_prev = 0; m_hist = {};
         for (int s = 0; s < SETS; s++) m_last[s] = 0;
         exp_dac = '0; exp_busy = 0;
         model_live = 1'b0;
      end else begin
         bit seen, edge_now, busy_prev;
         int wset;
         n = n + 1;
         busy_prev = (n-1 >= acc_c) && (n-1 <= end_c);
         m_hist.push_back(trig_in);
         if (m_hist.size() > SYNC) seen = m_hist.pop_front();
         else seen = 1'b0;
         edge_now = seen && !m_prev;
         m_prev = seen;
         if (edge_now && busy_prev) m_ov = 1;
         if (edge_now && !busy_prev) begin
            acc_c = n; m_set = int'(wave_sel); m_len = m_last[m_set];
            start_c = n + int'(delay_cycles) + 1;
            end_c = start_c + m_len;
         end
         if (n >= start_c && n <= end_c) exp_dac = m_mem[m_set*DEPTH + (n - start_c)];
         else exp_dac = '0;
         exp_busy = (n >= acc_c) && (n <= end_c);
         wset = int'(wr_addr[SEL_W+IDX_W-1 -: SEL_W]);
         if (wr_en && !(busy_prev && wset == m_set)) m_mem[wr_addr] = wr_data;
         if (len_wr_en && !(busy_prev && int'(len_wr_set) == m_set))
            m_last[len_wr_set] = int'(len_wr_last);
         model_live = 1'b1;
      end
   end

   always @(negedge clk) begin
      if (model_live && !done) begin
         checks++;
         if (dac_data !== exp_dac) begin
            errors++;
            $display("FAIL %s dac_data n=%0d actual=%h expected=%h", cur_tag, n, dac_data, exp_dac);
         end
         checks++;
         if (busy !== exp_busy) begin
            errors++;
            $display("FAIL R6 busy n=%0d actual=%b expected=%b", n, busy, exp_busy);
         end
         checks++;
         if (overrun !== m_ov) begin
            errors++;
            $display("FAIL R7 overrun n=%0d actual=%b expected=%b", n, overrun, m_ov);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic put_sample(input int set, input int idx, input logic [SAMPLE_W-1:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {SEL_W'(set), IDX_W'(idx)}; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic put_last(input int set, input int last);
      @(negedge clk);
      len_wr_en = 1'b1; len_wr_set = SEL_W'(set); len_wr_last = IDX_W'(last);
      @(negedge clk);
      len_wr_en = 1'b0;
   endtask

   task automatic load_set(input int set, input int last, input int seed);
      for (int i = 0; i <= last; i++) put_sample(set, i, SAMPLE_W'(seed + i*37 - 300));
      put_last(set, last);
   endtask

   task automatic pulse(input int high_cycles);
      @(negedge clk); trig_in = 1'b1;
      repeat (high_cycles) @(negedge clk);
      trig_in = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      cur_tag = "R1";
      repeat (5) @(negedge clk);
      // reset state: last index 0 -> a single sample chirp of set 0
      put_sample(0, 0, 16'h1234);
      cur_tag = "R11";
      delay_cycles = '0; wave_sel = 4'd0;
      pulse(1); wait_idle();

      cur_tag = "R10";
      load_set(3, 9, 1000);
      load_set(7, 4, -2000);
      load_set(12, 63, 5);

      cur_tag = "R2";
      wave_sel = 4'd3; delay_cycles = 12'd0;
      pulse(2); wait_idle();

      cur_tag = "R3";
      wave_sel = 4'd12; delay_cycles = 12'd1;
      pulse(1); wait_idle();

      cur_tag = "R5";
      wave_sel = 4'd7; delay_cycles = 12'd5;
      pulse(1);
      repeat (3) @(negedge clk);
      cur_tag = "R4";
      wave_sel = 4'd3; delay_cycles = 12'd40;
      wait_idle();

      cur_tag = "R7";
      wave_sel = 4'd12; delay_cycles = 12'd3;
      pulse(1);
      repeat (8) @(negedge clk);
      pulse(1);
      wait_idle();

      cur_tag = "R8";
      wave_sel = 4'd7; delay_cycles = 12'd2;
      pulse(60); wait_idle();

      cur_tag = "R9";
      wave_sel = 4'd12; delay_cycles = 12'd0;
      pulse(1);
      repeat (5) @(negedge clk);
      put_sample(12, 40, 16'hDEAD);
      put_last(12, 2);
      put_sample(3, 2, 16'h0BEE);
      put_last(3, 3);
      wait_idle();
      pulse(1); wait_idle();
      wave_sel = 4'd3;
      pulse(1); wait_idle();

      cur_tag = "R6";
      wave_sel = 4'd7; delay_cycles = 12'd0;
      pulse(1);
      while (busy) @(negedge clk);
      pulse(1); wait_idle();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog expired tag=%s actual=hung expected=finished", cur_tag);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule